// File: doc/BRIEF.md
# Ping-Pong Frame Pass Sequencer for Three-Pass Rotation

This block controls the external storage for an image rotation that is built from three one-dimensional shear passes. Two single-port synchronous frame memories take turns. In each pass one memory supplies words to the filter datapath and the other memory receives the filtered words. After the last filtered word of a pass is stored, the two memories swap roles. The three passes run in a fixed order: the first traverses the frame row by row, the second column by column, and the third row by row again. After the third pass the rotated frame is in memory 1.

Every memory word packs two 16-bit samples that are horizontally adjacent. The block runs on the memory clock, and each access moves one two-sample word. The column pass walks down a column of words with a stride of one row of words, so the filter receives the frame transposed. Words are also written back in that order, which returns the frame to its normal layout. The source picture sits in the top-left corner of the larger output frame. In the first pass, words outside the source area are not fetched and reach the filter as zero background. A one-cycle start request launches a rotation, and a one-cycle done pulse ends it.

Top module: `rot_pp_seq`

## Requirements
- R1: While reset is held and after it is released, with no start seen, no memory enable is asserted, and `done` and `flt_out_valid` are low.
- R2: The pass with index 0 reads memory 0 and writes memory 1. The pass with index 1 reads memory 1 and writes memory 0. The pass with index 2 reads memory 0 and writes memory 1.
- R3: Passes 0 and 2 are row-major. The word address is row*(FRM_W/2)+wordcol, and wordcol advances fastest.
- R4: Pass 1 is column-major. It uses the same address formula, but the row advances fastest, so consecutive addresses differ by one row of words.
- R5: Each access carries two 16-bit samples. `flt_out_valid` rises in the cycle after a read slot, and `flt_out_data` then holds the word from that slot.
- R6: In pass 0, a word whose row is at least SRC_H, or whose wordcol is at least SRC_W/2, is not fetched. Its slot is delivered as an all-zero word.
- R7: Each `flt_in_valid` cycle during a rotation writes `flt_in_data` in that same cycle. The write goes to the current write memory, at the next address of the pass traversal.
- R8: Reads of a pass start one per cycle, beginning in the cycle after `start` is accepted or after the last write of the previous pass.
- R9: `done` is a one-cycle pulse in the cycle after the last write of pass 2.
- R10: A `start` asserted while a rotation is in progress is ignored.
- R11: At most one memory is read per cycle, and each pass issues exactly (FRM_W/2)*FRM_H read slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle rotation request |
| done | output | 1 | One-cycle completion pulse |
| mem0_en | output | 1 | Memory 0 access enable |
| mem0_we | output | 1 | Memory 0 write enable |
| mem0_addr | output | ADDR_W | Memory 0 word address |
| mem0_wdata | output | 2*SAMPLE_W | Memory 0 write word |
| mem0_rdata | input | 2*SAMPLE_W | Memory 0 read word, one cycle after enable |
| mem1_en | output | 1 | Memory 1 access enable |
| mem1_we | output | 1 | Memory 1 write enable |
| mem1_addr | output | ADDR_W | Memory 1 word address |
| mem1_wdata | output | 2*SAMPLE_W | Memory 1 write word |
| mem1_rdata | input | 2*SAMPLE_W | Memory 1 read word, one cycle after enable |
| flt_out_valid | output | 1 | Word to filter is valid |
| flt_out_data | output | 2*SAMPLE_W | Two samples to filter |
| flt_in_valid | input | 1 | Filtered word is valid |
| flt_in_data | input | 2*SAMPLE_W | Two filtered samples |

## Verification
Suppose the pass counter holds a wrong value or the memory roles are out of step. The first read slot of the faulty pass then lands on the wrong memory enable or the wrong address, and that shows at the ports in the very cycle the slot is issued. Suppose instead a traversal counter wraps at the wrong point. The address stream then departs from the expected row-major or transposed order within one row or column of words. A zero-fill boundary error shows up one cycle later, on `flt_out_data`, as a nonzero word or a spurious fetch. A lost or extra restart moves `done` away from the cycle after the final write, and it also leaves the wrong frame in memory 1.

// File: rtl/rot_pp_pkg.sv
package rot_pp_pkg;
   // Pass index; bit 0 selects which memory is read during the pass.
   typedef enum logic [1:0] {
      PASS_ROW_A = 2'd0,
      PASS_COL   = 2'd1,
      PASS_ROW_B = 2'd2
   } pass_e;

   localparam int NUM_PASSES = 3;
endpackage

// File: rtl/rot_pp_addr_gen.sv
module rot_pp_addr_gen #(
   parameter int FRM_H    = 362,
   parameter int WPR      = 181,
   parameter int ADDR_W   = 16,
   parameter int SRC_ROWS = 256,
   parameter int SRC_COLS = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   input  logic              col_major,
   output logic [ADDR_W-1:0] addr,
   output logic              last,
   output logic              outside
);
   localparam int RW = $clog2(FRM_H);
   localparam int CW = $clog2(WPR);
   localparam logic [RW-1:0] ROW_MAX = RW'(FRM_H - 1);
   localparam logic [CW-1:0] COL_MAX = CW'(WPR - 1);

   generate
      if (FRM_H < 2 || WPR < 2) begin : g_bad_dim
         $error("rot_pp_addr_gen: frame needs at least two rows and two words per row");
      end
   endgenerate

   logic [RW-1:0] row;
   logic [CW-1:0] wcol;
   logic          row_end, col_end;

   assign row_end = (row == ROW_MAX);
   assign col_end = (wcol == COL_MAX);
   assign last    = row_end && col_end;
   assign outside = (int'(row) >= SRC_ROWS) || (int'(wcol) >= SRC_COLS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row  <= '0;
         wcol <= '0;
      end else if (clr) begin
         row  <= '0;
         wcol <= '0;
      end else if (step) begin
         if (col_major) begin
            if (row_end) begin
               row  <= '0;
               wcol <= col_end ? '0 : wcol + 1'b1;
            end else begin
               row <= row + 1'b1;
            end
         end else begin
            if (col_end) begin
               wcol <= '0;
               row  <= row_end ? '0 : row + 1'b1;
            end else begin
               wcol <= wcol + 1'b1;
            end
         end
      end
   end

   // Power-of-two row pitch packs fields; otherwise a constant multiply.
   generate
      if ((WPR & (WPR - 1)) == 0) begin : g_pack
         assign addr = (ADDR_W'(row) << CW) | ADDR_W'(wcol);
      end else begin : g_mul
         assign addr = ADDR_W'(row) * ADDR_W'(WPR) + ADDR_W'(wcol);
      end
   endgenerate

   a_r3_row_step : assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && !col_major && !col_end) |=> addr == $past(addr) + ADDR_W'(1));

   a_r4_col_stride : assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && col_major && !row_end) |=> addr == $past(addr) + ADDR_W'(WPR));
endmodule

// File: rtl/rot_pp_pass_ctrl.sv
module rot_pp_pass_ctrl
   import rot_pp_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start,
   input  logic  rd_last,
   input  logic  wr_fire,
   input  logic  wr_last,
   output logic  busy,
   output pass_e pass,
   output logic  rd_fire,
   output logic  clr,
   output logic  done
);
   logic rd_pend;
   logic accept, pass_end;

   assign accept   = start && !busy;
   assign pass_end = wr_fire && wr_last;
   assign clr      = accept || pass_end;
   assign rd_fire  = rd_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         pass    <= PASS_ROW_A;
         rd_pend <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= pass_end && (pass == PASS_ROW_B);
         if (accept) begin
            busy    <= 1'b1;
            pass    <= PASS_ROW_A;
            rd_pend <= 1'b1;
         end else begin
            if (rd_pend && rd_last) rd_pend <= 1'b0;
            if (pass_end) begin
               if (pass == PASS_ROW_B) begin
                  busy <= 1'b0;
               end else begin
                  pass    <= pass_e'(2'(pass) + 2'd1);
                  rd_pend <= 1'b1;
               end
            end
         end
      end
   end

   a_r9_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_start_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !pass_end) |=> (busy && pass == $past(pass)));

   a_r1_idle_no_read : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_fire);
endmodule

// File: rtl/rot_pp_seq.sv
module rot_pp_seq
   import rot_pp_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int SPW      = 2,
   parameter int FRM_W    = 362,
   parameter int FRM_H    = 362,
   parameter int SRC_W    = 256,
   parameter int SRC_H    = 256,
   parameter int ADDR_W   = $clog2((FRM_W / SPW) * FRM_H)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   output logic                    done,
   output logic                    mem0_en,
   output logic                    mem0_we,
   output logic [ADDR_W-1:0]       mem0_addr,
   output logic [SPW*SAMPLE_W-1:0] mem0_wdata,
   input  logic [SPW*SAMPLE_W-1:0] mem0_rdata,
   output logic                    mem1_en,
   output logic                    mem1_we,
   output logic [ADDR_W-1:0]       mem1_addr,
   output logic [SPW*SAMPLE_W-1:0] mem1_wdata,
   input  logic [SPW*SAMPLE_W-1:0] mem1_rdata,
   output logic                    flt_out_valid,
   output logic [SPW*SAMPLE_W-1:0] flt_out_data,
   input  logic                    flt_in_valid,
   input  logic [SPW*SAMPLE_W-1:0] flt_in_data
);
   localparam int WPR   = FRM_W / SPW;
   localparam int WORDS = WPR * FRM_H;
   localparam int DW    = SPW * SAMPLE_W;

   generate
      if (SPW != 2) begin : g_bad_spw
         $error("rot_pp_seq: each word must carry two samples");
      end
      if ((FRM_W % SPW) != 0 || (SRC_W % SPW) != 0) begin : g_bad_w
         $error("rot_pp_seq: widths must be whole words");
      end
      if (SRC_W > FRM_W || SRC_H > FRM_H) begin : g_bad_src
         $error("rot_pp_seq: source area exceeds frame");
      end
      if ((1 << ADDR_W) < WORDS) begin : g_bad_addr
         $error("rot_pp_seq: address too narrow for frame");
      end
   endgenerate

   pass_e             pass;
   logic              busy, rd_fire, clr, wr_fire;
   logic              rd_last, wr_last, rd_outside, wr_outside;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic              zero_fill, rd_mem, rd_bank, wr_bank;
   logic              unused_wr_outside;

   assign wr_fire           = flt_in_valid && busy;
   assign unused_wr_outside = wr_outside;

   rot_pp_pass_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .rd_last (rd_last),
      .wr_fire (wr_fire),
      .wr_last (wr_last),
      .busy    (busy),
      .pass    (pass),
      .rd_fire (rd_fire),
      .clr     (clr),
      .done    (done)
   );

   rot_pp_addr_gen #(
      .FRM_H(FRM_H), .WPR(WPR), .ADDR_W(ADDR_W),
      .SRC_ROWS(SRC_H), .SRC_COLS(SRC_W / SPW)
   ) u_rd_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .step      (rd_fire),
      .col_major (pass == PASS_COL),
      .addr      (rd_addr),
      .last      (rd_last),
      .outside   (rd_outside)
   );

   rot_pp_addr_gen #(
      .FRM_H(FRM_H), .WPR(WPR), .ADDR_W(ADDR_W),
      .SRC_ROWS(SRC_H), .SRC_COLS(SRC_W / SPW)
   ) u_wr_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .step      (wr_fire),
      .col_major (pass == PASS_COL),
      .addr      (wr_addr),
      .last      (wr_last),
      .outside   (wr_outside)
   );

   assign zero_fill = (pass == PASS_ROW_A) && rd_outside;
   assign rd_mem    = rd_fire && !zero_fill;
   assign rd_bank   = pass[0];
   assign wr_bank   = !pass[0];

   logic              bank_en   [2];
   logic              bank_we   [2];
   logic [ADDR_W-1:0] bank_addr [2];

   generate
      for (genvar b = 0; b < 2; b++) begin : g_bank
         logic is_rd, is_wr;
         assign is_rd        = rd_mem  && (rd_bank == 1'(b));
         assign is_wr        = wr_fire && (wr_bank == 1'(b));
         assign bank_en[b]   = is_rd || is_wr;
         assign bank_we[b]   = is_wr;
         assign bank_addr[b] = is_wr ? wr_addr : rd_addr;
      end
   endgenerate

   assign mem0_en    = bank_en[0];
   assign mem0_we    = bank_we[0];
   assign mem0_addr  = bank_addr[0];
   assign mem0_wdata = flt_in_data;
   assign mem1_en    = bank_en[1];
   assign mem1_we    = bank_we[1];
   assign mem1_addr  = bank_addr[1];
   assign mem1_wdata = flt_in_data;

   logic zero_q, bank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt_out_valid <= 1'b0;
         zero_q        <= 1'b0;
         bank_q        <= 1'b0;
      end else begin
         flt_out_valid <= rd_fire;
         zero_q        <= zero_fill;
         bank_q        <= rd_bank;
      end
   end

   assign flt_out_data = zero_q ? DW'(0) : (bank_q ? mem1_rdata : mem0_rdata);

   a_r8_next_pass_reads : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && wr_last && pass != PASS_ROW_B) |=> rd_fire);

   a_r6_zero_not_fetched : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && zero_fill) |-> !(mem0_en && !mem0_we));
endmodule

// File: tb/rot_pp_seq_tb_top.sv
`timescale 1ns/1ps
module rot_pp_seq_tb_top;
   localparam int FW = 6, FH = 4, SW = 4, SH = 3;
   localparam int WPR = FW / 2, WORDS = WPR * FH, AW = 4;
   localparam logic [31:0] K = 32'h0001_0001;

   typedef struct { int pass; int addr; bit zero; } ent_t;

   logic clk = 0, rst_n = 0, start = 0;
   logic done, mem0_en, mem0_we, mem1_en, mem1_we, flt_out_valid, flt_in_valid;
   logic [AW-1:0] mem0_addr, mem1_addr;
   logic [31:0] mem0_wdata, mem1_wdata, mem0_rdata, mem1_rdata, flt_out_data, flt_in_data;

   always #2.5 clk = ~clk;

   rot_pp_seq #(.FRM_W(FW), .FRM_H(FH), .SRC_W(SW), .SRC_H(SH), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done),
      .mem0_en(mem0_en), .mem0_we(mem0_we), .mem0_addr(mem0_addr),
      .mem0_wdata(mem0_wdata), .mem0_rdata(mem0_rdata),
      .mem1_en(mem1_en), .mem1_we(mem1_we), .mem1_addr(mem1_addr),
      .mem1_wdata(mem1_wdata), .mem1_rdata(mem1_rdata),
      .flt_out_valid(flt_out_valid), .flt_out_data(flt_out_data),
      .flt_in_valid(flt_in_valid), .flt_in_data(flt_in_data));

   // Memory models
   logic [31:0] m0 [WORDS];
   logic [31:0] m1 [WORDS];
   logic [31:0] img [WORDS];
   always @(posedge clk) begin
      if (mem0_en) begin
         if (mem0_we) m0[mem0_addr] <= mem0_wdata;
         else mem0_rdata <= m0[mem0_addr];
      end
      if (mem1_en) begin
         if (mem1_we) m1[mem1_addr] <= mem1_wdata;
         else mem1_rdata <= m1[mem1_addr];
      end
   end

   // Filter model: adds K, fixed latency lat
   int lat = 1;
   logic vp [8];
   logic [31:0] dp [8];
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) begin vp[i] <= 1'b0; dp[i] <= '0; end
      end else begin
         vp[0] <= flt_out_valid;
         dp[0] <= flt_out_data + K;
         for (int i = 1; i < 8; i++) begin vp[i] <= vp[i-1]; dp[i] <= dp[i-1]; end
      end
   end
   assign flt_in_valid = vp[lat-1];
   assign flt_in_data  = dp[lat-1];

   int checks = 0, errors = 0;
   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Reference model state
   ent_t rq[$];
   ent_t wq[$];
   logic [31:0] foq[$];
   int  mpass = -1;
   bit  rd_on = 0, first_rd = 0, done_exp = 0, running = 0;
   int  done_cnt = 0;

   function automatic bit outside_src(int a);
      return (a / WPR) >= SH || (a % WPR) >= SW / 2;
   endfunction

   task automatic build_queues();
      for (int p = 0; p < 3; p++) begin
         if (p == 1) begin
            for (int w = 0; w < WPR; w++)
               for (int r = 0; r < FH; r++) begin
                  rq.push_back('{p, r * WPR + w, 1'b0});
                  wq.push_back('{p, r * WPR + w, 1'b0});
               end
         end else begin
            for (int r = 0; r < FH; r++)
               for (int w = 0; w < WPR; w++) begin
                  rq.push_back('{p, r * WPR + w, p == 0 && (r >= SH || w >= SW / 2)});
                  wq.push_back('{p, r * WPR + w, 1'b0});
               end
         end
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && running) begin
         logic r0, r1;
         r0 = mem0_en && !mem0_we;
         r1 = mem1_en && !mem1_we;
         // R9: done timing
         check(done == done_exp, "R9 done timing", 64'(done), 64'(done_exp));
         if (done) done_cnt++;
         done_exp = 0;
         // R5: word to filter
         if (flt_out_valid) begin
            if (foq.size() == 0) check(0, "R5 unexpected valid", 1, 0);
            else begin
               logic [31:0] e;
               e = foq.pop_front();
               check(flt_out_data == e, "R5 R6 filter word", 64'(flt_out_data), 64'(e));
            end
         end else if (foq.size() > 0) begin
            void'(foq.pop_front());
            check(0, "R5 missing valid", 0, 1);
         end
         // Reads
         check(!(r0 && r1), "R11 one read per cycle", 64'({r0, r1}), 0);
         if (rd_on) begin
            ent_t e;
            e = rq.pop_front();
            if (first_rd) check(r0 || r1 || e.zero, "R8 pass reads start", 0, 1);
            first_rd = 0;
            if (e.zero) begin
               check(!r0 && !r1, "R6 no fetch outside source", 64'({r0, r1}), 0);
               foq.push_back(32'h0);
            end else if ((e.pass & 1) == 0) begin
               check(r0 && !r1 && mem0_addr == AW'(e.addr),
                     e.pass == 0 ? "R2 R3 read pass0" : "R2 R3 read pass2",
                     64'({r0, r1, mem0_addr}), 64'({2'b10, AW'(e.addr)}));
               foq.push_back(m0[e.addr]);
            end else begin
               check(r1 && !r0 && mem1_addr == AW'(e.addr), "R2 R4 read column pass",
                     64'({r0, r1, mem1_addr}), 64'({2'b01, AW'(e.addr)}));
               foq.push_back(m1[e.addr]);
            end
            if (rq.size() == 0 || rq[0].pass != mpass) rd_on = 0;
         end else begin
            check(!r0 && !r1, "R11 no extra read", 64'({r0, r1}), 0);
         end
         // Writes
         if (flt_in_valid && mpass >= 0) begin
            ent_t e;
            e = wq.pop_front();
            if (e.pass == 1)
               check(mem0_en && mem0_we && !mem1_we && mem0_addr == AW'(e.addr) &&
                     mem0_wdata == flt_in_data, "R2 R7 write mem0",
                     64'({mem0_we, mem0_addr, mem0_wdata}), 64'({1'b1, AW'(e.addr), flt_in_data}));
            else
               check(mem1_en && mem1_we && !mem0_we && mem1_addr == AW'(e.addr) &&
                     mem1_wdata == flt_in_data, "R2 R7 write mem1",
                     64'({mem1_we, mem1_addr, mem1_wdata}), 64'({1'b1, AW'(e.addr), flt_in_data}));
            if (wq.size() == 0 || wq[0].pass != mpass) begin
               if (mpass == 2) begin done_exp = 1; mpass = -1; end
               else begin mpass++; rd_on = 1; first_rd = 1; end
            end
         end else begin
            check(!mem0_we && !mem1_we, "R7 no stray write", 64'({mem0_we, mem1_we}), 0);
         end
         // R10: start only accepted when idle
         if (start && mpass == -1 && !done_exp) begin
            build_queues();
            mpass = 0; rd_on = 1; first_rd = 1;
         end
      end
   end

   task automatic pulse_start();
      @(posedge clk); #1 start = 1;
      @(posedge clk); #1 start = 0;
   endtask

   task automatic run_rotation(int seed);
      int wd;
      for (int i = 0; i < WORDS; i++) begin
         img[i] = {8'(seed), 8'(i), 8'(seed + 3), 8'(i * 5)};
         m0[i] = img[i];
         m1[i] = 32'hDEAD_BEEF;
      end
      done_cnt = 0;
      pulse_start();
      repeat (20) @(posedge clk);
      #1 start = 1;                        // R10: request while busy
      @(posedge clk); #1 start = 0;
      wd = 0;
      while (done_cnt == 0 && wd < 3000) begin @(posedge clk); wd++; end
      if (wd >= 3000) check(0, "R9 watchdog expired", 0, 1);
      repeat (5) @(posedge clk);
      check(done_cnt == 1, "R10 R9 single done", 64'(done_cnt), 1);
      for (int i = 0; i < WORDS; i++) begin
         logic [31:0] base;
         base = outside_src(i) ? 32'h0 : img[i];
         check(m1[i] == base + 3 * K, "R2 R6 final frame mem1", 64'(m1[i]), 64'(base + 3 * K));
         check(m0[i] == base + 2 * K, "R2 R4 column result mem0", 64'(m0[i]), 64'(base + 2 * K));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!mem0_en && !mem1_en && !done && !flt_out_valid, "R1 reset state",
            64'({mem0_en, mem1_en, done, flt_out_valid}), 0);
      @(posedge clk); #1 rst_n = 1;
      repeat (3) @(negedge clk);
      check(!mem0_en && !mem1_en && !done && !flt_out_valid, "R1 idle after reset",
            64'({mem0_en, mem1_en, done, flt_out_valid}), 0);
      running = 1;
      lat = 1;
      run_rotation(17);
      lat = 4;
      run_rotation(90);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule